// File: doc/BRIEF.md
# Keyed Watchdog Timer with Fixed-Width Reset Pulse

This block guards a system against stalled software. An 8-bit up counter advances once per oscillator clock. If software does not service it, the counter reaches its top value 0xFF. The block then drives a reset pulse of fixed length, 512 clocks. During the pulse the counter is frozen at zero. When the pulse ends, counting starts again from zero.

Software services the watchdog through a small write port that reaches two registers:

- **Key register** (`wr_sel` = 0): writing 0x55 arms the key logic, and a later write of 0xAA clears the counter. Writes of other values, and writes to the control register, may come between the two key values.
- **Control register** (`wr_sel` = 1): bit 0 set to 1 stops the counter, and no pulse can then be produced.

The block leaves reset enabled, with the counter at zero and the key logic waiting for 0x55.

Top module: `kwdt_top`

## Requirements
- R1: After the synchronous reset, the reset output is low, the counter is zero, counting is enabled and the key logic waits for 0x55.
- R2: While enabled and not pulsing, the counter rises by one per clock. The pulse starts on the clock edge at which the counter holds 0xFF, which is 256 edges after reset, after a clear, or after a pulse ends.
- R3: The reset output stays high for exactly 512 consecutive clocks.
- R4: While the pulse is high the counter is held at zero. It starts counting again on the first edge after the pulse falls, so the next pulse comes 256 edges after the fall.
- R5: Writing 0x55 to the key register (`wr_sel`=0) and later writing 0xAA to it clears the counter to zero on the edge of the 0xAA write.
- R6: A 0xAA key write that is not preceded by an arming 0x55 has no effect on the counter.
- R7: Once the key logic is armed, key writes of values other than 0x55/0xAA, control writes and repeated 0x55 writes leave it armed.
- R8: After a successful clear the key logic returns to waiting for 0x55, so a second 0xAA alone does not clear.
- R9: Bit 0 of a control write (`wr_sel`=1) set to 1 freezes the counter and blocks the pulse. Writing 0 to bit 0 resumes counting from the frozen value. The write takes effect after its own edge.
- R10: When a clearing 0xAA write lands on the edge at which the counter holds 0xFF, the clear wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_sel | input | 1 | Register select: 0 key, 1 control |
| wr_data | input | 8 | Write data |
| rst_pulse_o | output | 1 | Registered watchdog reset pulse |

## Verification
The bench measures in clock edges the time from each reference point (reset, a clear, the fall of a pulse, a disable window) to the next pulse. It compares each time with the number computed from how many edges have already elapsed. A design that counts a write edge wrongly, or restarts from the wrong value after a pulse, shows up as an off-by-one in these times. The bench drives a lone 0xAA, a 0xAA reused after a clear, and an arming sequence with filler writes in between. A key logic that forgets its armed state, or stays armed after a clear, then produces a pulse at the wrong time. A clear that lands exactly on the expiry edge checks that the clear takes priority. The disable test confirms that the counter resumes from its frozen value and not from zero.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic {
    KEY_WAIT = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/kwdt_regif.sv
module kwdt_regif
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ARM_KEY = 8'h55,
  parameter logic [DATA_W-1:0] FIRE_KEY = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              clr_o,
  output logic              disabled_o
);
  key_state_e state_q;
  logic key_wr, arm_hit, fire_hit;

  assign key_wr   = wr_en && !wr_sel;
  assign arm_hit  = key_wr && (wr_data == ARM_KEY);
  assign fire_hit = key_wr && (wr_data == FIRE_KEY);
  assign clr_o    = fire_hit && (state_q == KEY_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KEY_WAIT;
    end else if (clr_o) begin
      state_q <= KEY_WAIT;
    end else if (arm_hit) begin
      state_q <= KEY_ARMED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disabled_o <= 1'b0;
    end else if (wr_en && wr_sel) begin
      disabled_o <= wr_data[0];
    end
  end

  // R8: a successful clear sends the key logic back to waiting
  p_clear_rewaits_r8: assert property (@(posedge clk) disable iff (rst)
    (key_wr && wr_data == FIRE_KEY && state_q == KEY_ARMED) |=> (state_q == KEY_WAIT));

  // R7: writes that are not key values do not disturb the key state
  p_filler_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel || (wr_data != ARM_KEY && wr_data != FIRE_KEY))) |=> $stable(state_q));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             hold,
  input  logic             clr,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = enable && !hold && !clr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr || expire_o) begin
      cnt_q <= '0;
    end else if (enable && !hold) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: counter sits at zero while the pulse is active
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0));

  // R9: disabled counter is frozen unless cleared
  p_frozen_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clr && !hold) |=> $stable(cnt_q));

  // R5: an accepted clear zeroes the counter
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse_o
);
  localparam int REM_W = $clog2(PULSE_LEN);
  localparam logic [REM_W-1:0] REM_INIT = REM_W'(PULSE_LEN - 1);

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      rem_q   <= '0;
    end else if (pulse_o) begin
      if (rem_q == '0) begin
        pulse_o <= 1'b0;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end else if (start) begin
      pulse_o <= 1'b1;
      rem_q   <= REM_INIT;
    end
  end

  // R3: the pulse cannot end while time remains
  p_width_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && rem_q != '0) |=> pulse_o);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int CNT_W = 8,
  parameter int DATA_W = 8,
  parameter int PULSE_LEN = 512,
  parameter logic [DATA_W-1:0] ARM_KEY = 8'h55,
  parameter logic [DATA_W-1:0] FIRE_KEY = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic clr, disabled, expire;
  logic [CNT_W-1:0] cnt;

  kwdt_regif #(
    .DATA_W(DATA_W), .ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)
  ) regif_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_o(clr), .disabled_o(disabled)
  );

  kwdt_counter #(.CNT_W(CNT_W)) counter_i (
    .clk(clk), .rst(rst), .enable(!disabled), .hold(rst_pulse_o), .clr(clr),
    .expire_o(expire), .cnt_o(cnt)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst(rst), .start(expire), .pulse_o(rst_pulse_o)
  );

  // R2: a pulse only begins from a full counter
  p_fire_at_max_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pulse_o) |-> ($past(cnt) == CNT_MAX));

  // R9: a disabled watchdog never starts a pulse
  p_no_fire_off_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pulse_o) |-> !$past(disabled));

  // R10: an accepted clear suppresses expiry on the same edge
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !rst_pulse_o) |=> !rst_pulse_o);
endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int PERIOD = 256;
  localparam int WIDTH = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic rst_pulse_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  kwdt_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rst_pulse_o(rst_pulse_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic to_fire(output int n);
    n = 0;
    while (!rst_pulse_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic width(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (rst_pulse_o) w++; else break;
    end
  endtask

  task automatic fire_and_end(input string req, input int exp);
    int n, w;
    to_fire(n);
    check(req, n, exp);
    width(w);
    check("R3", w, WIDTH);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n, highs;
    idle(3);
    rst = 1'b0;
    check("R1 reset out", int'(rst_pulse_o), 0);
    // R1 R2: counting from zero, pulse after 256 edges
    fire_and_end("R2 from reset", PERIOD);
    // R4: restart from zero after the pulse
    fire_and_end("R4 restart", PERIOD);
    // R6: lone 0xAA does nothing
    idle(100); wr(1'b0, 8'hAA);
    fire_and_end("R6 lone AA", PERIOD - 101);
    // R5: arm then fire clears
    idle(50); wr(1'b0, 8'h55); wr(1'b0, 8'hAA);
    fire_and_end("R5 clear", PERIOD);
    // R7: filler writes between arm and fire, repeated arm
    idle(30); wr(1'b0, 8'h55); wr(1'b0, 8'h12); wr(1'b0, 8'hFF);
    wr(1'b1, 8'h00); wr(1'b0, 8'h55); wr(1'b0, 8'h00); wr(1'b0, 8'hAA);
    fire_and_end("R7 filler", PERIOD);
    // R8: after clear, 0xAA alone does not clear again
    idle(10); wr(1'b0, 8'h55); wr(1'b0, 8'hAA); idle(20); wr(1'b0, 8'hAA);
    fire_and_end("R8 rewait", PERIOD - 21);
    // R9: disable freezes and blocks, enable resumes from frozen value
    idle(40); wr(1'b1, 8'h01);
    highs = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (rst_pulse_o) highs++;
    end
    check("R9 no pulse while off", highs, 0);
    wr(1'b1, 8'h00);
    fire_and_end("R9 resume", PERIOD - 41);
    // R10: clear lands on the expiry edge
    idle(254); wr(1'b0, 8'h55);
    check("R10 before clear", int'(rst_pulse_o), 0);
    wr(1'b0, 8'hAA);
    check("R10 no pulse", int'(rst_pulse_o), 0);
    fire_and_end("R10 after clear", PERIOD);
    // R1: reset mid-count restarts from zero
    idle(77);
    rst = 1'b1; idle(2); rst = 1'b0;
    check("R1 reset out again", int'(rst_pulse_o), 0);
    to_fire(n);
    check("R1 R2 after reset", n, PERIOD);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule